// File: doc/BRIEF.md
# Six-Entry Dual-Clock FIFO with a Single-Bit-Step Pointer Code

This block carries data words between two unrelated clock domains through six storage slots. The writer works in its own clock. It offers a word with a write enable and sees a full flag. The reader works in the other clock. It pulls words with a read enable and sees an empty flag and an occupancy count. Both resets are active high, one per domain, and both must be asserted together before any traffic starts.

Each side addresses the storage with a plain binary slot index from 0 to 5. Each side also runs a pointer state machine whose state encoding is a 4-bit crossing code. That code is the only thing that leaves its domain, and it passes through a two-flop synchronizer. The code walks twelve positions and changes exactly one bit per step, including the wrap. Across the clock boundary a sample therefore always resolves to the old position or the new one. Six slots is not a power of two, so the code is built by hand. The first lap uses a six-code single-bit cycle with a leading 0. The second lap walks the same six codes in reverse with a leading 1. Each domain decodes its own position and the synchronized far position. Their difference modulo 12 is the occupancy.

Pointer state machine (one per domain). States and codes: C00=0000, C01=0001, C02=0011, C03=0111, C04=0101, C05=0100, C06=1100, C07=1101, C08=1111, C09=1011, C10=1001, C11=1000. State Ck is position k. Transitions: reset forces C00. An accepted operation (advance) moves Ck to Ck+1, and C11 goes to C00. With no accepted operation the state holds.

Top module: `cxf_fifo6`

## Requirements
- R1: While both resets are held and after their release with no traffic, rd_empty is 1, wr_full is 0 and rd_count is 0.
- R2: Words come out in the order they were accepted. rd_data updates on the rd_clk edge that accepts a read (rd_en high while rd_empty is low) and holds that word until the next accepted read.
- R3: The FIFO holds exactly six words. After six accepted writes with no reads, wr_full is 1 and rd_count is 6. rd_count never exceeds 6.
- R4: A write offered while wr_full is 1 is dropped. No word is stored, the write pointer does not move, and later reads return only the six earlier words.
- R5: A read offered while rd_empty is 1 is ignored. rd_data keeps its previous value and rd_count stays 0.
- R6: Each pointer follows the twelve-state code cycle C00..C11 listed above. Every step, including C11 to C00, changes exactly one bit. The binary slot index equals the position modulo 6.
- R7: Only the crossing code enters the other domain, through two flops. Every synchronized value is one of the twelve legal codes. Codes with low bits 10 (0010, 0110, 1010, 1110) never appear.
- R8: Once both sides have settled, rd_count equals accepted writes minus accepted reads. It is computed as (write position − read position) mod 12, and rd_empty means a count of 0 and wr_full a count of 6.
- R9: Status is never combinational across domains. A write does not clear rd_empty before the next rd_clk edge, and rd_empty is clear by the third rd_clk rising edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain reset, active high |
| wr_en | input | 1 | Offer wr_data this cycle |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Six words held, as seen by the writer |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain reset, active high |
| rd_en | input | 1 | Request the oldest word this cycle |
| rd_data | output | DATA_W | Registered read word |
| rd_empty | output | 1 | No words held, as seen by the reader |
| rd_count | output | 3 | Words held, as seen by the reader (0..6) |

## Verification
Suppose a pointer state machine skips or repeats a code, or its slot index drifts from its position. The read data stream then goes out of order or repeats a word, and the bench's reference queue catches this on the first read after the fault. A broken code table or occupancy decode shows up after the first wrap as a wrong rd_count, or as full or empty asserting at the wrong fill level, within about three clocks of the far domain. Long random traffic with unrelated periods drives both pointers through many laps, so every code step and the lap-bit flip are exercised.

// File: rtl/cxf_pkg.sv
package cxf_pkg;

    localparam int DEPTH  = 6;
    localparam int NPOS   = 2 * DEPTH;
    localparam int CODE_W = 4;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    // State encoding doubles as the crossing code: one bit flips per step.
    typedef enum logic [CODE_W-1:0] {
        C00 = 4'b0000, C01 = 4'b0001, C02 = 4'b0011, C03 = 4'b0111,
        C04 = 4'b0101, C05 = 4'b0100, C06 = 4'b1100, C07 = 4'b1101,
        C08 = 4'b1111, C09 = 4'b1011, C10 = 4'b1001, C11 = 4'b1000
    } code_e;

    function automatic logic [CODE_W-1:0] code_to_pos(input logic [CODE_W-1:0] c);
        logic [CODE_W-1:0] p;
        case (c)
            4'b0000: p = 4'd0;
            4'b0001: p = 4'd1;
            4'b0011: p = 4'd2;
            4'b0111: p = 4'd3;
            4'b0101: p = 4'd4;
            4'b0100: p = 4'd5;
            4'b1100: p = 4'd6;
            4'b1101: p = 4'd7;
            4'b1111: p = 4'd8;
            4'b1011: p = 4'd9;
            4'b1001: p = 4'd10;
            4'b1000: p = 4'd11;
            default: p = 4'd0;
        endcase
        return p;
    endfunction

    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        logic ok;
        case (c)
            4'b0010, 4'b0110, 4'b1010, 4'b1110: ok = 1'b0;
            default:                             ok = 1'b1;
        endcase
        return ok;
    endfunction

    // Occupancy: (near - far) modulo the twelve positions.
    function automatic logic [CODE_W-1:0] occupancy(input logic [CODE_W-1:0] wp,
                                                   input logic [CODE_W-1:0] rp);
        logic [CODE_W:0] d;
        d = {1'b0, wp} + 5'(NPOS) - {1'b0, rp};
        if (d >= 5'(NPOS)) d = d - 5'(NPOS);
        return d[CODE_W-1:0];
    endfunction

endpackage

// File: rtl/cxf_sync.sv
module cxf_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cxf_ptr_fsm.sv
module cxf_ptr_fsm
    import cxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] pos,
    output logic [IDX_W-1:0]  idx
);
    code_e state_q, state_nx;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        unique case (state_q)
            C00:     state_nx = C01;
            C01:     state_nx = C02;
            C02:     state_nx = C03;
            C03:     state_nx = C04;
            C04:     state_nx = C05;
            C05:     state_nx = C06;
            C06:     state_nx = C07;
            C07:     state_nx = C08;
            C08:     state_nx = C09;
            C09:     state_nx = C10;
            C10:     state_nx = C11;
            C11:     state_nx = C00;
            default: state_nx = C00;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)      state_q <= C00;
        else if (adv) state_q <= state_nx;
    end

    // Binary slot index, kept separately from the code
    always_ff @(posedge clk) begin
        if (rst)      idx_q <= '0;
        else if (adv) idx_q <= (idx_q == IDX_W'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            C00:     pos = 4'd0;
            C01:     pos = 4'd1;
            C02:     pos = 4'd2;
            C03:     pos = 4'd3;
            C04:     pos = 4'd4;
            C05:     pos = 4'd5;
            C06:     pos = 4'd6;
            C07:     pos = 4'd7;
            C08:     pos = 4'd8;
            C09:     pos = 4'd9;
            C10:     pos = 4'd10;
            C11:     pos = 4'd11;
            default: pos = 4'd0;
        endcase
    end

    assign code = state_q;
    assign idx  = idx_q;

    assert_one_bit_step_R6: assert property (@(posedge clk) disable iff (rst)
        adv |=> $countones(state_q ^ $past(state_q)) == 1);

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_q) && $stable(idx_q));

    assert_index_tracks_code_R6: assert property (@(posedge clk) disable iff (rst)
        idx_q == IDX_W'(32'(pos) % DEPTH));
endmodule

// File: rtl/cxf_fifo6.sv
module cxf_fifo6
    import cxf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic [CNT_W-1:0]  rd_count
);
    logic [DATA_W-1:0] mem [DEPTH];

    logic [CODE_W-1:0] wcode, wpos, rcode, rpos;
    logic [CODE_W-1:0] rcode_w, wcode_r;
    logic [CODE_W-1:0] used_w, used_r;
    logic [IDX_W-1:0]  widx, ridx;
    logic              wr_go, rd_go;

    // ---------------- write domain ----------------
    assign wr_go = wr_en && !wr_full;

    cxf_ptr_fsm u_wptr (
        .clk (wr_clk), .rst (wr_rst), .adv (wr_go),
        .code(wcode),  .pos (wpos),   .idx (widx)
    );

    cxf_sync #(.W(CODE_W), .STAGES(2)) u_rsync (
        .clk(wr_clk), .rst(wr_rst), .d(rcode), .q(rcode_w)
    );

    assign used_w  = occupancy(wpos, code_to_pos(rcode_w));
    assign wr_full = (used_w == 4'(DEPTH));

    always_ff @(posedge wr_clk) begin
        if (wr_go) mem[widx] <= wr_data;
    end

    // ---------------- read domain ----------------
    assign rd_go = rd_en && !rd_empty;

    cxf_ptr_fsm u_rptr (
        .clk (rd_clk), .rst (rd_rst), .adv (rd_go),
        .code(rcode),  .pos (rpos),   .idx (ridx)
    );

    cxf_sync #(.W(CODE_W), .STAGES(2)) u_wsync (
        .clk(rd_clk), .rst(rd_rst), .d(wcode), .q(wcode_r)
    );

    assign used_r   = occupancy(code_to_pos(wcode_r), rpos);
    assign rd_empty = (used_r == '0);
    assign rd_count = CNT_W'(used_r);

    always_ff @(posedge rd_clk) begin
        if (rd_rst)     rd_data <= '0;
        else if (rd_go) rd_data <= mem[ridx];
    end

    // ---------------- checks ----------------
    assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_full) |=> $stable(wcode));

    assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_empty) |=> $stable(rd_data) && $stable(rcode));

    assert_legal_far_code_rd_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        code_legal(wcode_r));

    assert_legal_far_code_wr_R7: assert property (@(posedge wr_clk) disable iff (wr_rst)
        code_legal(rcode_w));

    assert_count_bound_rd_R3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        used_r <= 4'(DEPTH));

    assert_count_bound_wr_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        used_w <= 4'(DEPTH));
endmodule

// File: tb/cxf_fifo6_tb.sv
`timescale 1ns/1ps
module cxf_fifo6_tb;

    localparam int DW = 8;
    localparam int NV = 17;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst = 1, rd_rst = 1;
    logic          wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_full, rd_empty;
    logic [DW-1:0] rd_data;
    logic [2:0]    rd_count;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5    wr_clk = ~wr_clk;   // 100 MHz
    always #6.85 rd_clk = ~rd_clk;   // unrelated

    cxf_fifo6 #(.DATA_W(DW)) u_dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
        .rd_empty(rd_empty), .rd_count(rd_count)
    );

    // {is_write, data (write data or expected read data), expected count}
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 8'hA1, 3'd1}, {1'b0, 8'hA1, 3'd0}, {1'b0, 8'hA1, 3'd0},
        {1'b1, 8'h10, 3'd1}, {1'b1, 8'h11, 3'd2}, {1'b1, 8'h12, 3'd3},
        {1'b1, 8'h13, 3'd4}, {1'b1, 8'h14, 3'd5}, {1'b1, 8'h15, 3'd6},
        {1'b1, 8'h99, 3'd6},
        {1'b0, 8'h10, 3'd5}, {1'b0, 8'h11, 3'd4}, {1'b0, 8'h12, 3'd3},
        {1'b0, 8'h13, 3'd2}, {1'b0, 8'h14, 3'd1}, {1'b0, 8'h15, 3'd0},
        {1'b0, 8'h15, 3'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
    endtask

    task automatic do_write(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en = 1; wr_data = d;
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic do_read();
        @(negedge rd_clk);
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
    endtask

    logic [DW-1:0] q[$];
    bit            wr_done = 0;

    initial begin
        int prev_cnt;
        // Reset: both domains together
        repeat (4) @(negedge wr_clk);
        check(rd_empty == 1, "R1 empty in reset", rd_empty, 1);
        check(wr_full == 0,  "R1 full in reset",  wr_full, 0);
        wr_rst = 0; rd_rst = 0;
        settle();
        check(rd_empty == 1, "R1 empty after reset", rd_empty, 1);
        check(wr_full == 0,  "R1 full after reset",  wr_full, 0);
        check(rd_count == 0, "R1 count after reset", rd_count, 0);

        // Vector table
        prev_cnt = 0;
        for (int i = 0; i < NV; i++) begin
            logic       is_w;
            logic [7:0] d;
            int         ec;
            is_w = VEC[i][11];
            d    = VEC[i][10:3];
            ec   = int'(VEC[i][2:0]);
            if (is_w) begin
                do_write(d);
            end else begin
                do_read();
                if (prev_cnt == 0)
                    check(rd_data == d, "R5 data held on empty read", rd_data, d);
                else
                    check(rd_data == d, "R2 read order", rd_data, d);
            end
            settle();
            if (is_w && prev_cnt == 6)
                check(rd_count == 3'(ec), "R4 count after dropped write", rd_count, ec);
            else if (!is_w && prev_cnt == 0)
                check(rd_count == 3'(ec), "R5 count after empty read", rd_count, ec);
            else
                check(rd_count == 3'(ec), "R8 count", rd_count, ec);
            check(wr_full == (ec == 6), "R3 full flag", wr_full, ec == 6);
            check(rd_empty == (ec == 0), "R8 empty flag", rd_empty, ec == 0);
            prev_cnt = ec;
        end

        // R9: status crosses with latency, not combinationally
        @(negedge wr_clk);
        wr_en = 1; wr_data = 8'h5A;
        @(posedge wr_clk);
        @(negedge wr_clk);
        wr_en = 0;
        check(rd_empty == 1, "R9 empty not cleared early", rd_empty, 1);
        repeat (3) @(posedge rd_clk);
        @(negedge rd_clk);
        check(rd_empty == 0, "R9 empty cleared by third edge", rd_empty, 0);
        do_read();
        check(rd_data == 8'h5A, "R2 read after latency test", rd_data, 8'h5A);
        settle();
        check(rd_empty == 1, "R8 empty after drain", rd_empty, 1);

        // Random traffic: many laps through the code cycle (R6, R7)
        fork
            begin
                for (int n = 0; n < 3000; n++) begin
                    @(negedge wr_clk);
                    wr_en   = ($urandom % 2) == 1;
                    wr_data = DW'($urandom);
                    if (wr_en && !wr_full) q.push_back(wr_data);
                end
                @(negedge wr_clk);
                wr_en = 0;
                wr_done = 1;
            end
            begin
                bit pend;
                pend = 0;
                while (!(wr_done && q.size() == 0 && !pend)) begin
                    @(negedge rd_clk);
                    if (pend) begin
                        if (q.size() == 0) begin
                            check(0, "R2 R6 R7 read with empty reference", rd_data, -1);
                        end else begin
                            logic [DW-1:0] e;
                            e = q.pop_front();
                            check(rd_data == e, "R2 R6 R7 random order", rd_data, e);
                        end
                    end
                    check(rd_count <= 3'd6, "R3 count bound", rd_count, 6);
                    rd_en = ($urandom % 2) == 1;
                    pend  = rd_en && !rd_empty;
                end
                rd_en = 0;
            end
        join

        settle();
        check(rd_empty == 1, "R8 empty at end", rd_empty, 1);
        check(wr_full == 0,  "R3 not full at end", wr_full, 0);
        check(rd_count == 0, "R8 count at end", rd_count, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule